// File: doc/BRIEF.md
# Flag-Setting 32-bit ALU

This block is the execute-stage arithmetic unit for a compact 16-bit instruction encoding. Each cycle it takes two 32-bit operands, a 5-bit immediate shift amount and a 4-bit operation code. It produces the 32-bit result combinationally in the same cycle. A status register holds four condition flags: negative, zero, carry and overflow. On the next rising clock edge the flags are loaded from that result, but only when the core asserts the flag-write enable.

Each operation updates its own set of flags. Add and subtract write all four. The logical operations and the multiply write only negative and zero. The shifts write negative, zero and a carry taken from the last bit shifted out, and they leave overflow alone. A left shift by zero also keeps the old carry. For right shifts, an immediate of zero means a shift by the full word width. Register file, decode and memory access sit outside the block.

Top module: `flag_alu`

## Requirements
- R1: Operation code 0 (add) gives a + b modulo 2^32. It writes carry with the unsigned carry out and overflow with two's-complement signed overflow.
- R2: Operation code 1 (subtract) gives a - b modulo 2^32. It writes carry as 1 when no borrow occurs (a >= b unsigned) and overflow as signed overflow.
- R3: For every defined code (0 to 9) with the flag-write enable high, the next flags hold negative = result bit 31 and zero = 1 exactly when the result is all zeros. The flag output packs {N,Z,C,V} into bits 3..0.
- R4: Codes 2 (AND a&b), 3 (OR a|b), 4 (XOR a^b) and 5 (NOT, ~b) produce the bitwise result. They update only negative and zero, so carry and overflow keep their previous values.
- R5: Code 9 (multiply) gives the low 32 bits of a*b. It updates only negative and zero.
- R6: Code 6 (left shift of a by the immediate s) gives a<<s with carry = a[32-s]. When s = 0 the result is a and carry is unchanged. No shift (codes 6, 7, 8) ever changes overflow.
- R7: Code 7 (logical right shift of a) fills with zeros, with carry = a[s-1]. When s = 0 it shifts by 32: the result is 0 and carry = a[31].
- R8: Code 8 (arithmetic right shift of a) replicates bit 31, with carry = a[s-1]. When s = 0 it shifts by 32: every result bit equals a[31] and carry = a[31].
- R9: While the flag-write enable is low, all four flags hold their values, whatever the operation.
- R10: Asynchronous active-low reset clears all four flags to 0.
- R11: Codes 10 to 15 are undefined. They give a zero result and leave all flags unchanged even with the flag-write enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand; the source for shifts |
| b_i | input | 32 | Second operand |
| shamt_i | input | 5 | Immediate shift amount |
| flag_we_i | input | 1 | Flag-write enable |
| result_o | output | 32 | Combinational result |
| flags_o | output | 4 | Status flags {N,Z,C,V} |

## Verification
The bench goes after the places where the carry source changes meaning. Subtract carry must be the inverse of borrow: a design using the raw borrow would report carry 0 for 5-5. A left shift by zero must keep the old carry: a design that loads bit 32 would clear it. A right shift by a zero immediate must act as a shift by 32: a design that passes a through unchanged would give a nonzero result and the wrong carry. The bench first sets carry and overflow to 1, then runs logical, multiply and shift operations to confirm they keep those bits. It also checks that an undefined code or a low enable leaves all four flags untouched.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_AND = 4'd2,
      OP_ORR = 4'd3,
      OP_EOR = 4'd4,
      OP_MVN = 4'd5,
      OP_LSL = 4'd6,
      OP_LSR = 4'd7,
      OP_ASR = 4'd8,
      OP_MUL = 4'd9
   } alu_op_e;

   localparam logic [OP_W-1:0] OP_LAST = 4'd9;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         carry_o,
   output logic         ovf_o
);
   logic [W-1:0] b_eff;
   logic [W:0]   total;

   // subtract is a + ~b + 1, so carry out is the inverse of borrow
   assign b_eff = b_i ^ {W{sub_i}};
   assign total = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};

   assign sum_o   = total[W-1:0];
   assign carry_o = total[W];
   assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (total[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import flag_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  alu_op_e      op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] res_o
);
   logic [W-1:0] prod;

   assign prod = a_i * b_i;   // low W bits kept

   always_comb begin
      case (op_i)
         OP_AND:  res_o = a_i & b_i;
         OP_ORR:  res_o = a_i | b_i;
         OP_EOR:  res_o = a_i ^ b_i;
         OP_MVN:  res_o = ~b_i;
         OP_MUL:  res_o = prod;
         default: res_o = '0;
      endcase
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int W      = 32,
   parameter int SW     = 5,
   parameter bit STAGED = 1'b1
) (
   input  logic [W-1:0]  a_i,
   input  logic [SW-1:0] amt_i,
   input  logic          right_i,
   input  logic          arith_i,
   output logic [W-1:0]  res_o,
   output logic          cout_o,
   output logic          cvalid_o
);
   localparam int EW = SW + 1;   // effective right amount reaches W

   logic [EW-1:0] eff_amt;
   logic          fill;
   logic [W:0]    lwide;   // {carry, result}
   logic [W:0]    rwide;   // {result, carry}

   assign eff_amt = (amt_i == '0) ? EW'(W) : {1'b0, amt_i};
   assign fill    = arith_i & a_i[W-1];

   if (STAGED) begin : g_staged
      always_comb begin
         lwide = {1'b0, a_i};
         for (int k = 0; k < SW; k++) begin
            if (amt_i[k]) lwide = lwide << (1 << k);
         end
      end
      always_comb begin
         rwide = {a_i, 1'b0};
         for (int k = 0; k < EW; k++) begin
            if (eff_amt[k]) begin
               rwide = (rwide >> (1 << k)) |
                       (fill ? ~({(W+1){1'b1}} >> (1 << k)) : '0);
            end
         end
      end
   end else begin : g_flat
      logic [W+1:0] rsrc;
      logic [W+1:0] rsh;
      assign rsrc  = {fill, a_i, 1'b0};
      assign rsh   = $unsigned($signed(rsrc) >>> eff_amt);
      assign lwide = {1'b0, a_i} << amt_i;
      assign rwide = rsh[W:0];
   end

   assign res_o    = right_i ? rwide[W:1] : lwide[W-1:0];
   assign cout_o   = right_i ? rwide[0]   : lwide[W];
   assign cvalid_o = right_i | (amt_i != '0);
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import flag_alu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  alu_flags_t d_i,
   output alu_flags_t q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (en_i) q_o <= d_i;
   end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import flag_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int SHAMT_W      = 5,
   parameter bit STAGED_SHIFT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         op_i,
   input  logic [DATA_W-1:0]  a_i,
   input  logic [DATA_W-1:0]  b_i,
   input  logic [SHAMT_W-1:0] shamt_i,
   input  logic               flag_we_i,
   output logic [DATA_W-1:0]  result_o,
   output logic [3:0]         flags_o
);
   if (DATA_W != (1 << SHAMT_W)) begin : g_bad_width
      $error("flag_alu: DATA_W must equal 2**SHAMT_W");
   end
   if (SHAMT_W < 1) begin : g_bad_shamt
      $error("flag_alu: SHAMT_W must be at least 1");
   end

   alu_op_e      op;
   logic         op_known;
   logic         is_arith, is_shift;
   logic [DATA_W-1:0] as_res, lg_res, sh_res;
   logic         as_c, as_v, sh_c, sh_cv;
   alu_flags_t   cur, nxt;

   assign op       = alu_op_e'(op_i);
   assign op_known = (op_i <= OP_LAST);
   assign is_arith = (op == OP_ADD) || (op == OP_SUB);
   assign is_shift = (op == OP_LSL) || (op == OP_LSR) || (op == OP_ASR);

   alu_addsub #(.W(DATA_W)) u_addsub (
      .a_i     (a_i),
      .b_i     (b_i),
      .sub_i   (op == OP_SUB),
      .sum_o   (as_res),
      .carry_o (as_c),
      .ovf_o   (as_v)
   );

   alu_logic #(.W(DATA_W)) u_logic (
      .op_i  (op),
      .a_i   (a_i),
      .b_i   (b_i),
      .res_o (lg_res)
   );

   alu_shifter #(.W(DATA_W), .SW(SHAMT_W), .STAGED(STAGED_SHIFT)) u_shift (
      .a_i      (a_i),
      .amt_i    (shamt_i),
      .right_i  ((op == OP_LSR) || (op == OP_ASR)),
      .arith_i  (op == OP_ASR),
      .res_o    (sh_res),
      .cout_o   (sh_c),
      .cvalid_o (sh_cv)
   );

   always_comb begin
      if (!op_known)     result_o = '0;
      else if (is_arith) result_o = as_res;
      else if (is_shift) result_o = sh_res;
      else               result_o = lg_res;
   end

   always_comb begin
      nxt.n = result_o[DATA_W-1];
      nxt.z = (result_o == '0);
      if (is_arith)                nxt.c = as_c;
      else if (is_shift && sh_cv)  nxt.c = sh_c;
      else                         nxt.c = cur.c;
      nxt.v = is_arith ? as_v : cur.v;
   end

   alu_flag_reg u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (flag_we_i && op_known),
      .d_i   (nxt),
      .q_o   (cur)
   );

   assign flags_o = cur;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic [3:0]         op_i,
   input logic [DATA_W-1:0]  a_i,
   input logic [DATA_W-1:0]  b_i,
   input logic [SHAMT_W-1:0] shamt_i,
   input logic               flag_we_i,
   input logic [DATA_W-1:0]  result_o,
   input logic [3:0]         flags_o
);
   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we_i |=> $stable(flags_o)); // R9

   AST_UNDEF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i > 4'd9) |=> $stable(flags_o)); // R11

   AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i > 4'd9) |-> (result_o == '0)); // R11

   AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && op_i <= 4'd9) |=> (flags_o[3] == $past(result_o[DATA_W-1]))); // R3

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && op_i <= 4'd9) |=> (flags_o[2] == ($past(result_o) == '0))); // R3

   AST_SUB_NOBORROW: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && op_i == 4'd1) |=> (flags_o[1] == ($past(a_i) >= $past(b_i)))); // R2

   AST_LOGIC_CV: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i >= 4'd2 && op_i <= 4'd5) |=> $stable(flags_o[1:0])); // R4

   AST_MUL_CV: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd9) |=> $stable(flags_o[1:0])); // R5

   AST_SHIFT_V: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i >= 4'd6 && op_i <= 4'd8) |=> $stable(flags_o[0])); // R6

   AST_LSL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd6 && shamt_i == '0) |=> $stable(flags_o[1])); // R6

   AST_LSR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd7 && shamt_i == '0) |-> (result_o == '0)); // R7
endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_i      (op_i),
   .a_i       (a_i),
   .b_i       (b_i),
   .shamt_i   (shamt_i),
   .flag_we_i (flag_we_i),
   .result_o  (result_o),
   .flags_o   (flags_o)
);

// File: tb/sim_flag_alu.sv
module sim_flag_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op = 4'd0;
   logic [31:0] a = '0, b = '0;
   logic [4:0]  sh = '0;
   logic        we = 1'b0;
   logic [31:0] res;
   logic [3:0]  flg;

   int checks = 0;
   int errors = 0;
   logic [3:0] exp_f = 4'b0000;   // {N,Z,C,V}

   always #10 clk = ~clk;

   flag_alu u0 (
      .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
      .shamt_i(sh), .flag_we_i(we), .result_o(res), .flags_o(flg)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference model built from the requirement text
   task automatic model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                        input logic [4:0] s, input logic [3:0] fi,
                        output logic [31:0] r, output logic [3:0] fo);
      logic n, z, c, v;
      logic [32:0] w;
      int amt;
      c = fi[1]; v = fi[0];
      r = '0;
      case (o)
         4'd0: begin w = {1'b0, x} + {1'b0, y}; r = w[31:0]; c = w[32];
                     v = (x[31] == y[31]) && (r[31] != x[31]); end
         4'd1: begin r = x - y; c = (x >= y);
                     v = (x[31] != y[31]) && (r[31] != x[31]); end
         4'd2: r = x & y;
         4'd3: r = x | y;
         4'd4: r = x ^ y;
         4'd5: r = ~y;
         4'd6: begin
            if (s == 0) r = x;
            else begin r = x << s; c = x[32 - int'(s)]; end
         end
         4'd7: begin
            amt = (s == 0) ? 32 : int'(s);
            r = (amt == 32) ? 32'd0 : (x >> amt);
            c = x[amt-1];
         end
         4'd8: begin
            amt = (s == 0) ? 32 : int'(s);
            r = (amt == 32) ? {32{x[31]}} : 32'($signed(x) >>> amt);
            c = x[amt-1];
         end
         4'd9: r = x * y;
         default: r = '0;
      endcase
      n = r[31]; z = (r == 0);
      fo = (o <= 4'd9) ? {n, z, c, v} : fi;
   endtask

   task automatic run(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                      input logic [4:0] s, input logic w, input string tag);
      logic [31:0] er;
      logic [3:0]  ef;
      @(negedge clk);
      op = o; a = x; b = y; sh = s; we = w;
      model(o, x, y, s, exp_f, er, ef);
      #2;
      chk(res === er, {tag, " result"}, res, er);
      @(negedge clk);
      if (w) exp_f = ef;
      chk(flg === exp_f, {tag, " flags"}, {28'd0, flg}, {28'd0, exp_f});
   endtask

   task automatic t_reset;
      chk(flg === 4'b0000, "R10 reset flags", {28'd0, flg}, 32'd0);
   endtask

   task automatic t_add;
      run(4'd0, 32'd1, 32'd2, 5'd0, 1'b1, "R1 add plain");
      run(4'd0, 32'hFFFF_FFFF, 32'd1, 5'd0, 1'b1, "R1 add carry zero R3");
      run(4'd0, 32'h7FFF_FFFF, 32'd1, 5'd0, 1'b1, "R1 add overflow R3");
   endtask

   task automatic t_sub;
      run(4'd1, 32'd5, 32'd5, 5'd0, 1'b1, "R2 sub equal");
      run(4'd1, 32'd0, 32'd1, 5'd0, 1'b1, "R2 sub borrow");
      run(4'd1, 32'h8000_0000, 32'd1, 5'd0, 1'b1, "R2 sub overflow");
   endtask

   task automatic t_set_cv;
      run(4'd0, 32'h8000_0000, 32'h8000_0000, 5'd0, 1'b1, "R1 set C V");
   endtask

   task automatic t_logic;
      t_set_cv();
      run(4'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, 5'd0, 1'b1, "R4 and");
      run(4'd3, 32'h8000_0000, 32'h0000_0001, 5'd0, 1'b1, "R4 orr");
      run(4'd4, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 5'd0, 1'b1, "R4 eor zero");
      run(4'd5, 32'h0, 32'h0000_FFFF, 5'd0, 1'b1, "R4 mvn");
   endtask

   task automatic t_mul;
      t_set_cv();
      run(4'd9, 32'h0001_0000, 32'h0001_0000, 5'd0, 1'b1, "R5 mul wrap zero");
      run(4'd9, 32'hFFFF_FFFD, 32'd7, 5'd0, 1'b1, "R5 mul negative");
   endtask

   task automatic t_lsl;
      t_set_cv();
      run(4'd6, 32'h1234_5678, 32'd0, 5'd0, 1'b1, "R6 lsl zero keeps C");
      run(4'd6, 32'h8000_0000, 32'd0, 5'd1, 1'b1, "R6 lsl one carry");
      run(4'd6, 32'h0000_0003, 32'd0, 5'd31, 1'b1, "R6 lsl thirtyone");
      run(4'd6, 32'h0000_0002, 32'd0, 5'd31, 1'b1, "R6 lsl out bit1");
   endtask

   task automatic t_lsr;
      t_set_cv();
      run(4'd7, 32'h8000_0001, 32'd0, 5'd0, 1'b1, "R7 lsr zero means 32");
      run(4'd7, 32'h8000_0003, 32'd0, 5'd1, 1'b1, "R7 lsr one");
      run(4'd7, 32'hF000_0000, 32'd0, 5'd28, 1'b1, "R7 lsr 28");
      run(4'd7, 32'h7FFF_FFFF, 32'd0, 5'd0, 1'b1, "R7 lsr 32 no carry");
   endtask

   task automatic t_asr;
      t_set_cv();
      run(4'd8, 32'h8000_0000, 32'd0, 5'd0, 1'b1, "R8 asr zero means 32");
      run(4'd8, 32'h8000_0018, 32'd0, 5'd4, 1'b1, "R8 asr four");
      run(4'd8, 32'h4000_0000, 32'd0, 5'd0, 1'b1, "R8 asr 32 positive");
   endtask

   task automatic t_hold;
      t_set_cv();
      run(4'd1, 32'd0, 32'd1, 5'd0, 1'b0, "R9 sub no write");
      run(4'd7, 32'h0, 32'd0, 5'd3, 1'b0, "R9 lsr no write");
   endtask

   task automatic t_undef;
      t_set_cv();
      for (int k = 10; k < 16; k++)
         run(4'(k), 32'hDEAD_BEEF, 32'h1234_5678, 5'd3, 1'b1, "R11 undefined op");
   endtask

   initial begin
      repeat (2) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_add();
      t_sub();
      t_logic();
      t_mul();
      t_lsl();
      t_lsr();
      t_asr();
      t_hold();
      t_undef();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule